// File: doc/BRIEF.md
# ASCII Hex Record Loader

This block takes a stream of ASCII characters, one per cycle when `ch_valid` is high. It picks out hexadecimal program records from that stream and writes their data bytes into an 8-bit-wide memory through a simple write port made of `wr_en`, `wr_addr` and `wr_data`. Each record opens with a colon. The header gives a byte count, a 16-bit starting address and a record kind. The data bytes follow, and a closing checksum byte ends the record.

Each byte is written as soon as its second character arrives. The block does not hold back the data of a record until the checksum is known. Once the checksum byte is complete, the block gives a one-cycle verdict on `rec_ok` or `rec_err`. A record that carries no data bytes and has a good checksum also raises `eof_pulse`. Any text between records is passed over until the next colon, so line breaks are harmless.

Top module: `hexrec_loader`

## Requirements
- R1: During and right after reset, `wr_en`, `rec_ok`, `rec_err` and `eof_pulse` are all low.
- R2: A record starts only at a colon (0x3A). Outside a record, every other character is discarded with no write and no pulse. This includes CR, LF, stray hex digits and other text.
- R3: The two hex characters after the colon give the number of data bytes N (0 to 255). Exactly N writes follow.
- R4: The next four hex characters give the load address, most significant digit first. Data byte k goes to that address plus k. The address wraps from 0xFFFF to 0x0000.
- R5: Every byte is sent as two hex characters, high nibble first. Digits 0-9, A-F and a-f are all accepted.
- R6: One cycle after the second checksum character, `rec_ok` pulses for one cycle if all record bytes after the colon, checksum included, add to 0 modulo 256. Otherwise `rec_err` pulses for one cycle. The two never pulse together.
- R7: `wr_en` is a one-cycle pulse, due one cycle after the second character of each data byte. Writes already made stay in place even when the checksum later fails.
- R8: The record-kind byte (the two characters after the address) must be 0x00. Any other value raises `rec_err` one cycle after its second character, makes no write, and the rest of the record is discarded until the next colon.
- R9: A character that is neither a hex digit nor a colon inside a record raises `rec_err` one cycle later and aborts the record. A colon inside a record raises `rec_err` and starts a fresh record from that colon.
- R10: A record with N = 0 and a good checksum raises `eof_pulse` in the same cycle as `rec_ok`. With a bad checksum it raises `rec_err` and no `eof_pulse`.
- R11: While `ch_valid` is low, `ch_data` has no effect on the parse state or the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_valid | input | 1 | `ch_data` holds a character this cycle |
| ch_data | input | 8 | ASCII character |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | ADDR_W | Write address (low ADDR_W bits of the 16-bit load address) |
| wr_data | output | 8 | Write data byte |
| rec_ok | output | 1 | Record checksum good (one-cycle pulse) |
| rec_err | output | 1 | Record failed: checksum, kind or bad character (one-cycle pulse) |
| eof_pulse | output | 1 | End-of-file record accepted (one-cycle pulse) |

## Verification
Every result of this block is registered on the same edge that takes in the character that causes it. A write, a verdict pulse or an end-of-file pulse is therefore due exactly one cycle after the triggering character: the second nibble of a data byte, the second checksum character, the second kind character, or the offending character. The bench presents each character on a falling edge and captures all outputs at the next falling edge, storing them by the index of that character in the record string. Each check then names the exact character index where the pulse must appear, and separate running counts confirm that nothing fired anywhere else.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COUNT,
    ST_ADDR,
    ST_KIND,
    ST_DATA,
    ST_CHECK
  } hx_state_t;

  localparam logic [7:0] COLON_CHAR = 8'h3A;

  // {is_hex, nibble}
  function automatic logic [4:0] hex_value(input logic [7:0] c);
    if (c >= 8'h30 && c <= 8'h39) return {1'b1, 4'(c - 8'h30)};
    if (c >= 8'h41 && c <= 8'h46) return {1'b1, 4'(c - 8'h37)};
    if (c >= 8'h61 && c <= 8'h66) return {1'b1, 4'(c - 8'h57)};
    return 5'd0;
  endfunction

  function automatic logic [7:0] sum_mod256(input logic [7:0] a, input logic [7:0] b);
    return 8'(a + b);
  endfunction

endpackage

// File: rtl/hexrec_char_decode.sv
module hexrec_char_decode
  import hexrec_pkg::*;
(
  input  logic [7:0] ch,
  output logic       is_hex,
  output logic [3:0] nib,
  output logic       is_colon
);
  logic [4:0] hv;
  always_comb begin
    hv       = hex_value(ch);
    is_hex   = hv[4];
    nib      = hv[3:0];
    is_colon = (ch == COLON_CHAR);
  end
endmodule

// File: rtl/hexrec_byte_pair.sv
module hexrec_byte_pair (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       nib_valid,
  input  logic [3:0] nib,
  output logic       byte_done,
  output logic [7:0] byte_val
);
  logic       low_phase;
  logic [3:0] hi_nib;

  assign byte_done = nib_valid && low_phase;
  assign byte_val  = {hi_nib, nib};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_phase <= 1'b0;
      hi_nib    <= 4'd0;
    end else if (clear) begin
      low_phase <= 1'b0;
    end else if (nib_valid) begin
      low_phase <= !low_phase;
      if (!low_phase) hi_nib <= nib;
    end
  end

  // R5: a byte completes only on the second nibble, so two completions never come back to back
  a_r5_pair_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done);
endmodule

// File: rtl/hexrec_cksum.sv
module hexrec_cksum
  import hexrec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       add_en,
  input  logic [7:0] add_byte,
  output logic       zero_with_byte
);
  logic [7:0] acc;

  assign zero_with_byte = (sum_mod256(acc, add_byte) == 8'd0);

  always_ff @(posedge clk) begin
    if (!rst_n)      acc <= 8'd0;
    else if (clear)  acc <= 8'd0;
    else if (add_en) acc <= sum_mod256(acc, add_byte);
  end
endmodule

// File: rtl/hexrec_loader.sv
module hexrec_loader
  import hexrec_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ch_valid,
  input  logic [7:0]        ch_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              rec_ok,
  output logic              rec_err,
  output logic              eof_pulse
);
  localparam int LOAD_W = 16;
  localparam int CNT_W  = 8;

  hx_state_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  len_r;
  logic [LOAD_W-1:0] addr_r;

  logic       is_hex, is_colon;
  logic [3:0] nib;
  logic       in_rec, rec_start, rec_abort, hex_in;
  logic       byte_done, sum_zero;
  logic [7:0] byte_val;

  hexrec_char_decode u_dec (
    .ch(ch_data), .is_hex(is_hex), .nib(nib), .is_colon(is_colon)
  );

  assign in_rec    = (state != ST_IDLE);
  assign rec_start = ch_valid && is_colon;
  assign rec_abort = ch_valid && in_rec && !is_hex && !is_colon;
  assign hex_in    = ch_valid && in_rec && is_hex;

  hexrec_byte_pair u_pair (
    .clk(clk), .rst_n(rst_n), .clear(rec_start),
    .nib_valid(hex_in), .nib(nib),
    .byte_done(byte_done), .byte_val(byte_val)
  );

  hexrec_cksum u_sum (
    .clk(clk), .rst_n(rst_n), .clear(rec_start),
    .add_en(byte_done), .add_byte(byte_val),
    .zero_with_byte(sum_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      len_r     <= '0;
      addr_r    <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      rec_ok    <= 1'b0;
      rec_err   <= 1'b0;
      eof_pulse <= 1'b0;
    end else begin
      wr_en     <= 1'b0;
      rec_ok    <= 1'b0;
      rec_err   <= 1'b0;
      eof_pulse <= 1'b0;
      if (rec_start) begin
        if (in_rec) rec_err <= 1'b1;
        state <= ST_COUNT;
        cnt   <= '0;
      end else if (rec_abort) begin
        rec_err <= 1'b1;
        state   <= ST_IDLE;
      end else if (byte_done) begin
        unique case (state)
          ST_COUNT: begin
            len_r <= byte_val;
            cnt   <= '0;
            state <= ST_ADDR;
          end
          ST_ADDR: begin
            if (cnt == '0) begin
              addr_r[15:8] <= byte_val;
              cnt          <= CNT_W'(1);
            end else begin
              addr_r[7:0] <= byte_val;
              state       <= ST_KIND;
            end
          end
          ST_KIND: begin
            cnt <= '0;
            if (byte_val != 8'd0) begin
              rec_err <= 1'b1;
              state   <= ST_IDLE;
            end else if (len_r == '0) begin
              state <= ST_CHECK;
            end else begin
              state <= ST_DATA;
            end
          end
          ST_DATA: begin
            wr_en   <= 1'b1;
            wr_addr <= addr_r[ADDR_W-1:0];
            wr_data <= byte_val;
            addr_r  <= LOAD_W'(addr_r + 1'b1);
            cnt     <= CNT_W'(cnt + 1'b1);
            if (CNT_W'(cnt + 1'b1) == len_r) state <= ST_CHECK;
          end
          ST_CHECK: begin
            if (sum_zero) begin
              rec_ok    <= 1'b1;
              eof_pulse <= (len_r == '0);
            end else begin
              rec_err <= 1'b1;
            end
            state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // ---------------- checker state and assertions ----------------
  logic              valid_q;
  logic              have_prev;
  logic [ADDR_W-1:0] prev_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      have_prev <= 1'b0;
      prev_addr <= '0;
    end else begin
      valid_q <= ch_valid;
      if (rec_start) have_prev <= 1'b0;
      else if (wr_en) have_prev <= 1'b1;
      if (wr_en) prev_addr <= wr_addr;
    end
  end

  // R6: verdicts are exclusive
  a_r6_verdict_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rec_ok && rec_err));
  // R6: verdict is a single-cycle pulse
  a_r6_ok_single: assert property (@(posedge clk) disable iff (!rst_n)
    rec_ok |=> !rec_ok);
  // R10: end of file only with a good verdict
  a_r10_eof_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
    eof_pulse |-> rec_ok);
  // R7: write strobe lasts one cycle
  a_r7_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  // R4: consecutive writes inside one record climb by one
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && have_prev && !rec_start) |-> (wr_addr == ADDR_W'(prev_addr + 1'b1)));
  // R11: no output event follows a cycle without a character
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> (!wr_en && !rec_ok && !rec_err && !eof_pulse));
endmodule

// File: tb/hexrec_loader_tb_top.sv
`timescale 1ns/1ps
module hexrec_loader_tb_top;
  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ch_valid = 1'b0;
  logic [7:0]        ch_data = 8'h00;
  logic              wr_en, rec_ok, rec_err, eof_pulse;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;

  always #2.5 clk = ~clk;

  hexrec_loader #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_data(ch_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rec_ok(rec_ok), .rec_err(rec_err), .eof_pulse(eof_pulse)
  );

  int vectors = 0;
  int fails   = 0;

  // per-character captures (index = position in the sent string)
  logic [63:0] cap_wr, cap_ok, cap_err, cap_eof;
  // running log
  int   n_wr, n_ok, n_err, n_eof;
  int   log_addr [32];
  int   log_data [32];

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en) begin
        if (n_wr < 32) begin
          log_addr[n_wr] = int'(wr_addr);
          log_data[n_wr] = int'(wr_data);
        end
        n_wr++;
      end
      if (rec_ok)    n_ok++;
      if (rec_err)   n_err++;
      if (eof_pulse) n_eof++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    n_wr = 0; n_ok = 0; n_err = 0; n_eof = 0;
    cap_wr = '0; cap_ok = '0; cap_err = '0; cap_eof = '0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic send_char(input logic [7:0] c, input int idx);
    @(negedge clk);
    ch_data  = c;
    ch_valid = 1'b1;
    @(negedge clk);
    if (idx < 64) begin
      cap_wr[idx]  = wr_en;
      cap_ok[idx]  = rec_ok;
      cap_err[idx] = rec_err;
      cap_eof[idx] = eof_pulse;
    end
    ch_valid = 1'b0;
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send_char(s[i], i);
  endtask

  task automatic t_reset();
    chk("R1", "wr_en after reset", int'(wr_en), 0);
    chk("R1", "rec_ok after reset", int'(rec_ok), 0);
    chk("R1", "rec_err after reset", int'(rec_err), 0);
    chk("R1", "eof after reset", int'(eof_pulse), 0);
  endtask

  task automatic t_example();
    clear_logs();
    send_str(":0300010053F8ECC5");
    chk("R7", "no write after first data nibble", int'(cap_wr[9]), 0);
    chk("R7", "write after second data nibble", int'(cap_wr[10]), 1);
    chk("R6", "ok at last checksum char", int'(cap_ok[16]), 1);
    chk("R6", "ok not before last char", int'(cap_ok[15]), 0);
    settle();
    chk("R3", "write count", n_wr, 3);
    chk("R4", "addr0", log_addr[0], 1);
    chk("R4", "addr1", log_addr[1], 2);
    chk("R4", "addr2", log_addr[2], 3);
    chk("R5", "data0", log_data[0], 'h53);
    chk("R5", "data1", log_data[1], 'hF8);
    chk("R5", "data2", log_data[2], 'hEC);
    chk("R6", "ok count", n_ok, 1);
    chk("R6", "err count", n_err, 0);
  endtask

  task automatic t_between();
    clear_logs();
    send_str("\r\nzz");
    // R11: a colon with valid low must not open a record
    @(negedge clk); ch_data = 8'h3A; ch_valid = 1'b0;
    repeat (3) @(negedge clk);
    send_str("01000000AA55");
    settle();
    chk("R2", "writes outside record", n_wr, 0);
    chk("R2", "pulses outside record", n_ok + n_err + n_eof, 0);
    // R11: junk with valid low in the middle of a record
    clear_logs();
    send_str(":0100");
    @(negedge clk); ch_data = "G"; ch_valid = 1'b0;
    repeat (3) @(negedge clk);
    send_str("30004D82");
    settle();
    chk("R11", "write survives idle junk", n_wr, 1);
    chk("R11", "addr", log_addr[0], 'h30);
    chk("R11", "data", log_data[0], 'h4D);
    chk("R11", "ok", n_ok, 1);
    chk("R11", "no err", n_err, 0);
  endtask

  task automatic t_badsum();
    clear_logs();
    send_str(":0300010053F8ECC6");
    chk("R6", "err at last checksum char", int'(cap_err[16]), 1);
    settle();
    chk("R7", "writes kept on bad sum", n_wr, 3);
    chk("R6", "no ok on bad sum", n_ok, 0);
    chk("R6", "one err", n_err, 1);
  endtask

  task automatic t_kind();
    clear_logs();
    send_str(":0100000155A9");
    chk("R8", "err after kind byte", int'(cap_err[8]), 1);
    chk("R8", "no err before kind end", int'(cap_err[7]), 0);
    settle();
    chk("R8", "no writes", n_wr, 0);
    chk("R8", "single err, rest ignored", n_err, 1);
    chk("R8", "no ok", n_ok, 0);
  endtask

  task automatic t_badchar();
    clear_logs();
    send_str(":01G5000000");
    chk("R9", "err at bad char", int'(cap_err[3]), 1);
    settle();
    chk("R9", "one err only", n_err, 1);
    chk("R9", "no writes", n_wr, 0);
    clear_logs();
    send_str(":01:010020007E61");
    chk("R9", "err at inner colon", int'(cap_err[3]), 1);
    chk("R9", "ok on restarted record", int'(cap_ok[15]), 1);
    settle();
    chk("R9", "restart write count", n_wr, 1);
    chk("R9", "restart addr", log_addr[0], 'h20);
    chk("R9", "restart data", log_data[0], 'h7E);
    chk("R9", "restart err count", n_err, 1);
  endtask

  task automatic t_wrap_lower();
    clear_logs();
    send_str(":02FFFF00abcd88");
    settle();
    chk("R4", "wrap write count", n_wr, 2);
    chk("R4", "addr before wrap", log_addr[0], 'hFFFF);
    chk("R4", "addr after wrap", log_addr[1], 0);
    chk("R5", "lowercase data0", log_data[0], 'hAB);
    chk("R5", "lowercase data1", log_data[1], 'hCD);
    chk("R6", "wrap ok", n_ok, 1);
  endtask

  task automatic t_eof();
    clear_logs();
    send_str(":0000000000");
    chk("R10", "eof at last char", int'(cap_eof[10]), 1);
    chk("R10", "ok with eof", int'(cap_ok[10]), 1);
    settle();
    chk("R10", "no writes on eof", n_wr, 0);
    chk("R10", "one eof", n_eof, 1);
    clear_logs();
    send_str(":0000000001");
    chk("R10", "bad eof err", int'(cap_err[10]), 1);
    settle();
    chk("R10", "no eof on bad sum", n_eof, 0);
    chk("R10", "no ok on bad sum", n_ok, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_example();
    t_between();
    t_badsum();
    t_kind();
    t_badchar();
    t_wrap_lower();
    t_eof();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    vectors++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule